// File: doc/BRIEF.md
# Checksummed Serial Configuration Receiver

This block is a write-only configuration port that listens on three lines: serial data, serial clock and a frame strobe. While the strobe is low, each rising edge of the serial clock shifts one data bit into a 48-bit frame, least significant bit first. On the rising edge of the strobe the frame is evaluated. It is accepted only when four things hold: a full frame arrived, the chip-select byte matches, the category code is legal, and the byte checksum passes. The 28-bit payload of an accepted frame is written to one of four category registers: mode, shutter, phase, or system.

All three serial lines are brought into the system clock domain through a synchronizer chain and edge detectors. The category registers are held as plain outputs for the consumer blocks, which apply the values later in line timing. A two-bit operating state is decoded from the mode register. It takes effect in the same cycle the mode register is written. A status output can be selected to show the result of the checksum for the last frame.

Top module: `cfg_serial_rx`

## Requirements
- R1: A frame is 48 bits sent least significant bit first. Bits 7:0 are the chip byte, bits 11:8 the category, bits 39:12 the 28-bit payload and bits 47:40 the checksum byte. The payload of an accepted frame appears unchanged on the selected category register.
- R2: A frame is discarded unless its chip byte equals 8'h81, that is bits 0 and 7 set and bits 1 to 6 clear.
- R3: Category 4'h0 writes mode_cfg, 4'h2 writes shut_cfg, 4'h3 writes phase_cfg and 4'h4 writes sys_cfg. A phase frame with a nonzero payload is discarded, so phase_cfg stays zero. Every other category code is discarded and no register changes.
- R4: The checksum passes when the six frame bytes sum to zero modulo 256. A frame whose checksum fails is discarded. When the check-enable bit (sys_cfg bit 5, frame bit 17) of the previously committed system register is 0, the checksum always passes.
- R5: When the status-select bit (sys_cfg bit 6, frame bit 18) is 1, cfg_stat takes the frame result at the strobe rise: 1 when the frame was complete and its checksum passed, 0 otherwise. It returns to 1 at the strobe fall. When the status-select bit is 0, cfg_stat is 0.
- R6: op_state follows mode_cfg bits 7:6 (frame bits 19:18) in the same cycle mode_cfg is written. Value 00 gives 0 (run), 01 gives 1 (sleep), and 1x gives 2 (standby).
- R7: The bit count restarts when the strobe falls. A frame with fewer than 48 clock rises since the strobe fell is not committed. With more than 48, the last 48 bits form the frame.
- R8: An active-low reset clears all four category registers, so op_state is 0 and cfg_stat is 0.
- R9: With the default two-stage synchronizer, a register write appears after the third system clock rising edge following the strobe rise, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_dat | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial clock, sampled on its rising edge |
| ser_stb | input | 1 | Frame strobe, low while shifting, rise commits |
| mode_cfg | output | 28 | Mode category register |
| shut_cfg | output | 28 | Shutter category register |
| phase_cfg | output | 28 | Phase category register |
| sys_cfg | output | 28 | System category register |
| op_state | output | 2 | Decoded operating state |
| cfg_stat | output | 1 | Checksum status output |

## Verification
Every serial line passes two synchronizer flops and one edge-detect flop. A bit, a commit, op_state and the status output therefore change after the third system clock rising edge that follows the input edge. The bench drives all inputs on falling clock edges. It holds each serial level for at least three cycles and reads results four falling edges after the strobe rise, one edge after they are due. The latency test also samples after exactly two and after exactly three edges to confirm the cycle. The status return is checked three edges after the strobe falls.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;

   // Category selector codes; the decoder routes on these values.
   typedef enum logic [3:0] {
      CAT_MODE  = 4'h0,
      CAT_SHUT  = 4'h2,
      CAT_PHASE = 4'h3,
      CAT_SYS   = 4'h4
   } cat_e;

   // Slot index of each category register.
   localparam int SLOT_MODE  = 0;
   localparam int SLOT_SHUT  = 1;
   localparam int SLOT_PHASE = 2;
   localparam int SLOT_SYS   = 3;
   localparam int NUM_SLOTS  = 4;

   typedef enum logic [1:0] {
      OP_RUN   = 2'd0,
      OP_SLEEP = 2'd1,
      OP_STBY  = 2'd2
   } op_e;

   // Result of evaluating one frame.
   typedef struct packed {
      logic                 pass;    // complete and checksum satisfied
      logic                 accept;  // pass plus chip and category legal
      logic [NUM_SLOTS-1:0] wr;      // one-hot register select
   } verdict_t;

endpackage

// File: rtl/cfgrx_sync.sv
module cfgrx_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0,
   parameter bit          BYPASS  = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cfgrx_sync: STAGES must be at least 2");
   end

   if (BYPASS) begin : g_direct
      // Lines already timed to clk: pass straight through.
      assign q_o = d_i;
   end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
         end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
         end
      end

      assign q_o = stage_q[STAGES-1];
   end

endmodule

// File: rtl/cfgrx_shift.sv
module cfgrx_shift #(
   parameter int FRAME_W = 48
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_i,
   input  logic               sclk_rise_i,
   input  logic               stb_fall_i,
   input  logic               stb_low_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic               full_o
);

   localparam int CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   logic [FRAME_W-1:0] sr_q;
   logic [CNT_W-1:0]   cnt_q;

   // LSB first: new bits enter at the top and move down, so after a
   // full frame the first bit sits at position 0.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (stb_fall_i) begin
         cnt_q <= '0;
      end else if (sclk_rise_i && stb_low_i) begin
         sr_q <= {bit_i, sr_q[FRAME_W-1:1]};
         if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign frame_o = sr_q;
   assign full_o  = (cnt_q == CNT_FULL);

   // R7: the bit count saturates at one frame
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);

   // R7: nothing shifts while the strobe is high
   p_hold_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_low_i |=> $stable(frame_o));

endmodule

// File: rtl/cfgrx_decode.sv
module cfgrx_decode
   import cfgrx_pkg::*;
#(
   parameter int               FRAME_W    = 48,
   parameter int               CHIP_W     = 8,
   parameter int               CAT_W      = 4,
   parameter int               DATA_W     = 28,
   parameter int               SUM_W      = 8,
   parameter logic [CHIP_W-1:0] CHIP_ID   = 8'h81
) (
   input  logic [FRAME_W-1:0] frame_i,
   input  logic               full_i,
   input  logic               chk_en_i,
   output verdict_t           verdict_o
);

   localparam int NBYTES   = FRAME_W / SUM_W;
   localparam int DATA_LSB = CHIP_W + CAT_W;

   // Modulo byte sum as a chain of adders, one per frame byte.
   logic [SUM_W-1:0] part [NBYTES+1];
   assign part[0] = '0;
   for (genvar b = 0; b < NBYTES; b++) begin : g_sum
      assign part[b+1] = part[b] + frame_i[b*SUM_W +: SUM_W];
   end

   logic [CHIP_W-1:0] chip;
   logic [CAT_W-1:0]  cat;
   logic [DATA_W-1:0] data;
   logic              sum_ok;
   logic              chip_ok;
   logic              cat_ok;
   logic [NUM_SLOTS-1:0] sel;

   assign chip    = frame_i[0 +: CHIP_W];
   assign cat     = frame_i[CHIP_W +: CAT_W];
   assign data    = frame_i[DATA_LSB +: DATA_W];
   assign sum_ok  = (part[NBYTES] == '0) || !chk_en_i;
   assign chip_ok = (chip == CHIP_ID);

   always_comb begin
      sel    = '0;
      cat_ok = 1'b1;
      case (cat)
         CAT_MODE:  sel[SLOT_MODE] = 1'b1;
         CAT_SHUT:  sel[SLOT_SHUT] = 1'b1;
         CAT_PHASE: begin
            // Phase frames must carry an all-zero payload.
            if (data == '0) sel[SLOT_PHASE] = 1'b1;
            else            cat_ok = 1'b0;
         end
         CAT_SYS:   sel[SLOT_SYS] = 1'b1;
         default:   cat_ok = 1'b0;
      endcase
   end

   always_comb begin
      verdict_o.pass   = full_i && sum_ok;
      verdict_o.accept = verdict_o.pass && chip_ok && cat_ok;
      verdict_o.wr     = verdict_o.accept ? sel : '0;
   end

endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
   import cfgrx_pkg::*;
#(
   parameter int               FRAME_W      = 48,
   parameter int               CHIP_W       = 8,
   parameter int               CAT_W        = 4,
   parameter int               DATA_W       = 28,
   parameter int               SUM_W        = 8,
   parameter logic [CHIP_W-1:0] CHIP_ID     = 8'h81,
   parameter int               SYNC_STAGES  = 2,
   parameter bit               SYNC_BYPASS  = 1'b0,
   parameter int               CHK_EN_BIT   = 5,
   parameter int               STAT_SEL_BIT = 6,
   parameter int               OP_LSB       = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_dat,
   input  logic              ser_clk,
   input  logic              ser_stb,
   output logic [DATA_W-1:0] mode_cfg,
   output logic [DATA_W-1:0] shut_cfg,
   output logic [DATA_W-1:0] phase_cfg,
   output logic [DATA_W-1:0] sys_cfg,
   output logic [1:0]        op_state,
   output logic              cfg_stat
);

   localparam int DATA_LSB = CHIP_W + CAT_W;

   // Elaboration-time parameter checks
   if (FRAME_W != CHIP_W + CAT_W + DATA_W + SUM_W) begin : g_bad_frame
      $error("cfg_serial_rx: field widths do not add up to FRAME_W");
   end
   if (FRAME_W % SUM_W != 0) begin : g_bad_sum
      $error("cfg_serial_rx: FRAME_W must be a whole number of checksum words");
   end
   if (CAT_W != 4) begin : g_bad_cat
      $error("cfg_serial_rx: category field must be 4 bits");
   end
   if (CHK_EN_BIT >= DATA_W || STAT_SEL_BIT >= DATA_W || OP_LSB + 1 >= DATA_W) begin : g_bad_bit
      $error("cfg_serial_rx: control bit outside payload");
   end

   // Synchronize {strobe, clock, data}; strobe idles high.
   logic [2:0] line_s;
   cfgrx_sync #(
      .W      (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(3'b100),
      .BYPASS (SYNC_BYPASS)
   ) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({ser_stb, ser_clk, ser_dat}),
      .q_o  (line_s)
   );

   logic stb_s, sclk_s, dat_s;
   assign {stb_s, sclk_s, dat_s} = line_s;

   logic stb_d, sclk_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_d  <= 1'b1;
         sclk_d <= 1'b0;
      end else begin
         stb_d  <= stb_s;
         sclk_d <= sclk_s;
      end
   end

   logic stb_rise, stb_fall, sclk_rise;
   assign stb_rise  =  stb_s && !stb_d;
   assign stb_fall  = !stb_s &&  stb_d;
   assign sclk_rise =  sclk_s && !sclk_d;

   logic [FRAME_W-1:0] frame;
   logic               full;
   cfgrx_shift #(.FRAME_W(FRAME_W)) shift_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_i      (dat_s),
      .sclk_rise_i(sclk_rise),
      .stb_fall_i (stb_fall),
      .stb_low_i  (!stb_s),
      .frame_o    (frame),
      .full_o     (full)
   );

   logic [DATA_W-1:0] cfg_q [NUM_SLOTS];
   verdict_t          verdict;

   cfgrx_decode #(
      .FRAME_W(FRAME_W), .CHIP_W(CHIP_W), .CAT_W(CAT_W),
      .DATA_W (DATA_W),  .SUM_W (SUM_W),  .CHIP_ID(CHIP_ID)
   ) decode_i (
      .frame_i  (frame),
      .full_i   (full),
      .chk_en_i (cfg_q[SLOT_SYS][CHK_EN_BIT]),
      .verdict_o(verdict)
   );

   logic commit;
   assign commit = stb_rise && verdict.accept;

   // One register per category
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       cfg_q[s] <= '0;
         else if (commit && verdict.wr[s]) cfg_q[s] <= frame[DATA_LSB +: DATA_W];
      end
   end

   assign mode_cfg  = cfg_q[SLOT_MODE];
   assign shut_cfg  = cfg_q[SLOT_SHUT];
   assign phase_cfg = cfg_q[SLOT_PHASE];
   assign sys_cfg   = cfg_q[SLOT_SYS];

   // Operating state applies as soon as the mode register changes.
   op_e op;
   always_comb begin
      if (mode_cfg[OP_LSB+1])   op = OP_STBY;
      else if (mode_cfg[OP_LSB]) op = OP_SLEEP;
      else                       op = OP_RUN;
   end
   assign op_state = op;

   // Status: result latched at strobe rise, back high at strobe fall.
   logic stat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat_q <= 1'b1;
      else if (stb_rise) stat_q <= verdict.pass;
      else if (stb_fall) stat_q <= 1'b1;
   end
   assign cfg_stat = sys_cfg[STAT_SEL_BIT] ? stat_q : 1'b0;

   // R3: at most one category register is selected
   p_wr_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(verdict.wr));

   // R3: phase register can only ever hold zero
   p_phase_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      phase_cfg == '0);

   // R4: registers hold when no frame is committed
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable({mode_cfg, shut_cfg, phase_cfg, sys_cfg}));

   // R7: only a complete frame may be committed
   p_commit_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> full);

   // R6: standby code wins over sleep
   p_op_stby_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_cfg[OP_LSB+1] |-> (op_state == OP_STBY));

   // R5: with status selected, the output is high after a strobe fall
   p_stat_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_fall && sys_cfg[STAT_SEL_BIT]) |=> (cfg_stat || !sys_cfg[STAT_SEL_BIT]));

endmodule

// File: tb/cfg_serial_rx_tb.sv
`timescale 1ns/1ps
module cfg_serial_rx_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_dat = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_stb = 1'b1;
   logic [27:0] mode_cfg, shut_cfg, phase_cfg, sys_cfg;
   logic [1:0]  op_state;
   logic        cfg_stat;

   always #2 clk = ~clk;

   cfg_serial_rx dut_i (
      .clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .ser_clk(ser_clk),
      .ser_stb(ser_stb), .mode_cfg(mode_cfg), .shut_cfg(shut_cfg),
      .phase_cfg(phase_cfg), .sys_cfg(sys_cfg), .op_state(op_state),
      .cfg_stat(cfg_stat)
   );

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   // Bench model of the registers
   logic [27:0] m_mode = '0, m_shut = '0, m_phase = '0, m_sys = '0;
   logic        m_statq = 1'b1;

   typedef struct packed {
      logic [7:0]  chip;
      logic [3:0]  cat;
      logic [27:0] data;
      logic        bad;
      logic        acc;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{8'h81, 4'h0, 28'h00000A5, 1'b0, 1'b1},  // R1 mode, standby code
      '{8'h81, 4'h2, 28'h1234567, 1'b0, 1'b1},  // R1 shutter
      '{8'h80, 4'h2, 28'h0FFFFFF, 1'b0, 1'b0},  // R2 bit0 clear
      '{8'h83, 4'h2, 28'h0EEEEEE, 1'b0, 1'b0},  // R2 bit1 set
      '{8'h81, 4'h1, 28'h0DDDDDD, 1'b0, 1'b0},  // R3 prohibited code
      '{8'h81, 4'h3, 28'h0000000, 1'b0, 1'b1},  // R3 phase zero
      '{8'h81, 4'h3, 28'h0000001, 1'b0, 1'b0},  // R3 phase nonzero
      '{8'h81, 4'h4, 28'h0000060, 1'b0, 1'b1},  // R4/R5 check and status on
      '{8'h81, 4'h2, 28'h0ABCDEF, 1'b1, 1'b0},  // R4 bad sum rejected
      '{8'h81, 4'h0, 28'h0000040, 1'b0, 1'b1},  // R6 sleep
      '{8'h81, 4'h5, 28'h0CCCCCC, 1'b0, 1'b0},  // R3 prohibited, sum ok
      '{8'h81, 4'h4, 28'h0000040, 1'b0, 1'b1},  // R4 check off, status on
      '{8'h81, 4'h0, 28'h0000000, 1'b1, 1'b1},  // R4 bad sum passes, check off
      '{8'h81, 4'h4, 28'h0000000, 1'b0, 1'b1}   // R5 status off
   };

   function automatic logic [47:0] mk(input logic [7:0] chip, input logic [3:0] cat,
                                      input logic [27:0] data, input logic bad);
      logic [39:0] body;
      logic [7:0]  s;
      body = {data, cat, chip};
      s = '0;
      for (int i = 0; i < 5; i++) s = s + body[i*8 +: 8];
      s = 8'h00 - s;
      if (bad) s = s + 8'h01;
      return {s, body};
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic put_bit(input logic b);
      ser_dat = b;
      step(2);
      ser_clk = 1'b1;
      step(3);
      ser_clk = 1'b0;
      step(3);
   endtask

   // Strobe low, optional leading junk bit, then nbits of the frame.
   task automatic load(input logic [47:0] f, input int nbits, input bit junk);
      ser_stb = 1'b0;
      step(4);
      if (junk) put_bit(1'b1);
      for (int i = 0; i < nbits; i++) put_bit(f[i]);
      step(2);
   endtask

   task automatic send(input logic [47:0] f);
      load(f, 48, 1'b0);
      ser_stb = 1'b1;
      step(4);
   endtask

   function automatic logic [1:0] exp_op(input logic [27:0] m);
      return m[7] ? 2'd2 : (m[6] ? 2'd1 : 2'd0);
   endfunction

   task automatic check_all(input string req);
      check(req, "mode_cfg",  {4'h0, mode_cfg},  {4'h0, m_mode});
      check(req, "shut_cfg",  {4'h0, shut_cfg},  {4'h0, m_shut});
      check(req, "phase_cfg", {4'h0, phase_cfg}, {4'h0, m_phase});
      check(req, "sys_cfg",   {4'h0, sys_cfg},   {4'h0, m_sys});
      check("R6", "op_state", {30'h0, op_state}, {30'h0, exp_op(m_mode)});
      check("R5", "cfg_stat", {31'h0, cfg_stat}, {31'h0, m_sys[6] & m_statq});
   endtask

   // Apply one table entry to the model (complete frames only).
   task automatic model(input vec_t v);
      m_statq = !v.bad || !m_sys[5];
      if (v.acc) begin
         case (v.cat)
            4'h0: m_mode  = v.data;
            4'h2: m_shut  = v.data;
            4'h3: m_phase = v.data;
            4'h4: m_sys   = v.data;
            default: ;
         endcase
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(3);
      // R8: reset state
      check_all("R8");

      // Table walk: R1..R6
      for (int k = 0; k < NV; k++) begin
         send(mk(VEC[k].chip, VEC[k].cat, VEC[k].data, VEC[k].bad));
         model(VEC[k]);
         check_all(k < 2 ? "R1" : (k < 7 ? "R3" : "R4"));
      end

      // R9: commit latency, mode frame with sleep code
      load(mk(8'h81, 4'h0, 28'h0000041, 1'b0), 48, 1'b0);
      ser_stb = 1'b1;
      step(2);
      check("R9", "mode after 2 edges", {4'h0, mode_cfg}, {4'h0, m_mode});
      step(1);
      m_mode = 28'h0000041;
      check("R9", "mode after 3 edges", {4'h0, mode_cfg}, {4'h0, m_mode});
      check("R6", "op_state sleep", {30'h0, op_state}, 32'd1);
      step(2);

      // R7: 47 bits only, nothing committed
      load(mk(8'h81, 4'h2, 28'h0777777, 1'b0), 47, 1'b0);
      ser_stb = 1'b1;
      step(4);
      check("R7", "shut_cfg partial", {4'h0, shut_cfg}, {4'h0, m_shut});

      // R7: 49 bits, last 48 form the frame
      load(mk(8'h81, 4'h2, 28'h0555AAA, 1'b0), 48, 1'b1);
      ser_stb = 1'b1;
      step(4);
      m_shut = 28'h0555AAA;
      check("R7", "shut_cfg extra bit", {4'h0, shut_cfg}, {4'h0, m_shut});

      // R5: fail shows low, strobe fall restores high
      send(mk(8'h81, 4'h4, 28'h0000060, 1'b0));
      m_sys = 28'h0000060;
      send(mk(8'h81, 4'h2, 28'h0123123, 1'b1));
      check("R5", "cfg_stat fail", {31'h0, cfg_stat}, 32'd0);
      check("R4", "shut_cfg kept", {4'h0, shut_cfg}, {4'h0, m_shut});
      ser_stb = 1'b0;
      step(3);
      check("R5", "cfg_stat after fall", {31'h0, cfg_stat}, 32'd1);
      ser_stb = 1'b1;
      step(4);
      check("R5", "cfg_stat partial frame", {31'h0, cfg_stat}, 32'd0);

      // R8: reset in the middle of operation
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(2);
      m_mode = '0; m_shut = '0; m_phase = '0; m_sys = '0; m_statq = 1'b1;
      check_all("R8");

      finish_run();
   end

endmodule